// File: doc/BRIEF.md
# I2C Target Interface with Selectable SDA Hold

This block is a byte-oriented I2C target that runs on a fast system clock. It samples the bus lines after a two-flop synchronizer, detects start, repeated start and stop conditions, and compares each address byte with a programmable 7-bit address. After a match it either collects write data from the bus controller or sends read data supplied by the host. It acknowledges every byte it receives.

SDA is driven open-drain. The data output is tied to zero and only the output enable moves. Every change of that enable waits a hold interval after each SCL falling edge. A control input picks a short or a long interval, and the long one suits heavily loaded buses. While the block is sending and leaves SDA released for a one, it reports a collision if it reads SDA back low.

Host traffic uses two byte streams. Read data enters through `tx_data`/`tx_valid`/`tx_ready`. The host holds `tx_valid` and `tx_data` steady until `tx_ready` pulses. The block cannot stretch the clock, so it has no back-pressure. If no byte is valid when one is due, it sends 0xFF and leaves `tx_ready` low. Write data leaves on `rx_data`/`rx_valid` as a single-cycle pulse, with no ready, and the host must accept it on that cycle.

Top module: `i2c_target_hold`

## Requirements
- R1: After reset, `sda_oe`, `rx_valid`, `tx_ready`, `addressed` and `coll` are all low, and `sda_out` is always 0.
- R2: When the first byte after a start has its upper 7 bits (first seven bits on the wire, MSB first) equal to `own_addr`, the block pulls SDA low during the ninth clock and raises `addressed`.
- R3: When those 7 bits differ from `own_addr`, the block gives no acknowledge, keeps `addressed` low and drives SDA on no clock until the next start.
- R4: When the address byte's last bit (R/W) is 0, each following byte is captured MSB first and presented on `rx_data` with a one-cycle `rx_valid` pulse after its eighth SCL fall, and the block acknowledges it.
- R5: When the R/W bit is 1, the block sends one byte per 9-clock segment, MSB first. It takes `tx_data` at the start of each byte and pulses `tx_ready` for one cycle if `tx_valid` is high. Otherwise it sends 0xFF.
- R6: If the controller answers a sent byte with NACK (SDA high on the ninth clock), the block drives SDA on no clock until the next start or stop.
- R7: Every change of `sda_oe` happens exactly HOLD_SHORT+2 cycles (`hold_long`=0) or HOLD_LONG+2 cycles (`hold_long`=1) after the first clock edge that samples SCL low, and never while synchronized SCL is high.
- R8: `coll` pulses for one cycle when, on an SCL rise during a sent data bit, the block has SDA released and samples it low.
- R9: With `en` low, `sda_oe` is low from the next cycle and the block returns to idle.
- R10: A repeated start returns the block to address reception. A stop returns it to idle with `addressed` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| hold_long | input | 1 | 1 selects the long SDA hold interval |
| own_addr | input | 7 | Target address |
| scl_in | input | 1 | SCL as seen on the bus |
| sda_in | input | 1 | SDA as seen on the bus |
| sda_out | output | 1 | SDA output data, fixed 0 |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_data | output | 8 | Received write byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Byte to send on a read |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | One-cycle strobe, byte taken |
| addressed | output | 1 | Block is selected or is receiving an address |
| coll | output | 1 | One-cycle collision strobe |

## Verification
The hold-window and SCL-low properties assume that each SCL low phase outlasts the long hold plus the synchronizer delay. They also assume that `hold_long` changes only while the bus is idle. The stimulus keeps SCL low for 60 cycles and high for 60 cycles, against a long hold of 15. It moves `hold_long` only between transactions. The bench changes its own SDA only while SCL is low, except for the deliberate start and stop edges and the forced-low bit in the collision test.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = BYTE_BITS - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  // SDA edge while SCL stays high marks a bus condition
  assign start_cond = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_cond  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_hold_timer.sv
module i2ct_hold_timer #(
  parameter int HOLD_SHORT = 2,
  parameter int HOLD_LONG  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hold_long,
  input  logic scl_fall,
  input  logic want_low,
  output logic sda_oe
);
  localparam int HMAX = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
  localparam int CW   = $clog2(HMAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (scl_fall) begin
      cnt <= hold_long ? CW'(HOLD_LONG) : CW'(HOLD_SHORT);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) sda_oe <= want_low;
    end
  end
endmodule

// File: rtl/i2ct_proto_fsm.sv
module i2ct_proto_fsm
  import i2ct_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 sda_s,
  input  logic                 start_cond,
  input  logic                 stop_cond,
  input  logic                 sda_oe,
  input  logic [BYTE_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [BYTE_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 want_low,
  output logic                 addressed,
  output logic                 coll
);
  localparam int BW = BYTE_BITS;
  localparam int CW = $clog2(BW + 1);

  tgt_state_e    state;
  logic [CW-1:0] bit_cnt;
  logic [BW-1:0] shreg, txsh;
  logic          rw, mack;
  logic          last_bit;
  logic [BW-1:0] tx_pick;

  assign last_bit  = (bit_cnt == CW'(BW));
  assign tx_pick   = tx_valid ? tx_data : '1;
  assign addressed = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      txsh     <= '1;
      rw       <= 1'b0;
      mack     <= 1'b0;
      want_low <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      tx_ready <= 1'b0;
      coll     <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_ready <= 1'b0;
      coll     <= 1'b0;
      if (!en) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        want_low <= 1'b0;
      end else if (start_cond) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        want_low <= 1'b0;
      end else if (stop_cond) begin
        state    <= ST_IDLE;
        want_low <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg   <= {shreg[BW-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && last_bit) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[BW-1:1] == own_addr) begin
                  rw       <= shreg[0];
                  want_low <= 1'b1;
                  state    <= ST_AACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                rx_data  <= shreg;
                rx_valid <= 1'b1;
                want_low <= 1'b1;
                state    <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (rw) begin
                txsh     <= tx_pick;
                tx_ready <= tx_valid;
                want_low <= ~tx_pick[BW-1];
                state    <= ST_RD;
              end else begin
                want_low <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              want_low <= 1'b0;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (!sda_oe && !sda_s) coll <= 1'b1;
            end else if (scl_fall) begin
              if (last_bit) begin
                bit_cnt  <= '0;
                want_low <= 1'b0;
                state    <= ST_RACK;
              end else begin
                txsh     <= {txsh[BW-2:0], 1'b0};
                want_low <= ~txsh[BW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txsh     <= tx_pick;
                tx_ready <= tx_valid;
                want_low <= ~tx_pick[BW-1];
                state    <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_hold.sv
module i2c_target_hold #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_SHORT  = 2,
  parameter int HOLD_LONG   = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       hold_long,
  input  logic [6:0] own_addr,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_out,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       addressed,
  output logic       coll
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_cond, stop_cond;
  logic want_low;

  assign sda_out = 1'b0;

  i2ct_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_cond(start_cond), .stop_cond(stop_cond)
  );

  i2ct_proto_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .en(en), .own_addr(own_addr),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_cond(start_cond), .stop_cond(stop_cond), .sda_oe(sda_oe),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .want_low(want_low),
    .addressed(addressed), .coll(coll)
  );

  i2ct_hold_timer #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) hold_i (
    .clk(clk), .rst_n(rst_n), .en(en), .hold_long(hold_long),
    .scl_fall(scl_fall), .want_low(want_low), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int HOLD_SHORT = 2,
  parameter int HOLD_LONG  = 15
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic hold_long,
  input logic scl_s,
  input logic scl_fall,
  input logic sda_oe,
  input logic rx_valid,
  input logic tx_valid,
  input logic tx_ready,
  input logic coll
);
  localparam int HMAX = (HOLD_LONG > HOLD_SHORT) ? HOLD_LONG : HOLD_SHORT;
  localparam int SW   = $clog2(HMAX + 2);

  logic [SW-1:0] since_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        since_fall <= '0;
    else if (scl_fall)                 since_fall <= SW'(1);
    else if (since_fall != SW'(HMAX + 1)) since_fall <= since_fall + 1'b1;
  end

  AST_OE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sda_oe)) |->
      (since_fall >= (hold_long ? SW'(HOLD_LONG) : SW'(HOLD_SHORT)))); // R7
  AST_OE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sda_oe)) |-> !scl_s); // R7
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R4
  AST_TX_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_valid); // R5
  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready); // R5
  AST_COLL_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    coll |-> !sda_oe); // R8
  AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_oe); // R9
endmodule

bind i2c_target_hold i2ct_checker #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .hold_long(hold_long), .scl_s(scl_s),
  .scl_fall(scl_fall), .sda_oe(sda_oe), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .coll(coll)
);

// File: tb/i2c_target_hold_tb_top.sv
`timescale 1ns/1ps
module i2c_target_hold_tb_top;
  localparam int HS = 2;
  localparam int HL = 15;
  localparam int Q  = 30;
  localparam logic [6:0] MY_ADDR = 7'h3A;
  // {hold_long, addr7, data, expect_ack}
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 7'h3A, 8'h00, 1'b1},
    {1'b1, 7'h3A, 8'hFF, 1'b1},
    {1'b0, 7'h3A, 8'h96, 1'b1},
    {1'b1, 7'h3B, 8'h12, 1'b0},
    {1'b0, 7'h1D, 8'h55, 1'b0},
    {1'b1, 7'h3A, 8'h81, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic hold_long = 1'b0;
  logic scl_in = 1'b1;
  logic m_sda = 1'b1;
  logic sda_in;
  logic sda_out, sda_oe, rx_valid, tx_ready, addressed, coll;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign sda_in = m_sda & ~sda_oe;

  i2c_target_hold #(.HOLD_SHORT(HS), .HOLD_LONG(HL)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .hold_long(hold_long), .own_addr(MY_ADDR),
    .scl_in(scl_in), .sda_in(sda_in), .sda_out(sda_out), .sda_oe(sda_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .addressed(addressed), .coll(coll)
  );

  // monitors
  int rx_cnt = 0, rdy_cnt = 0, coll_cnt = 0, oe_cycles = 0;
  logic [7:0] last_rx = 8'h00;
  int since = 0, last_delay = 0;
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; last_rx <= rx_data; end
    if (tx_ready) rdy_cnt <= rdy_cnt + 1;
    if (coll) coll_cnt <= coll_cnt + 1;
    if (sda_oe) oe_cycles <= oe_cycles + 1;
    since <= (scl_in == 1'b0) ? since + 1 : 0;
    if (sda_oe !== oe_prev) last_delay <= since;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl_in = 1'b1; wn(Q);
    m_sda = 1'b0; wn(Q);
    scl_in = 1'b0; wn(Q);
  endtask

  task automatic bus_restart();
    m_sda = 1'b1; wn(Q);
    scl_in = 1'b1; wn(Q);
    m_sda = 1'b0; wn(Q);
    scl_in = 1'b0; wn(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wn(Q);
    scl_in = 1'b1; wn(Q);
    m_sda = 1'b1; wn(Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    wn(Q); m_sda = b; wn(Q);
    scl_in = 1'b1; wn(Q);
    r = sda_in; wn(Q);
    scl_in = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
    clk_bit(~give_ack, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic ack, ack2;
    logic [7:0] d;
    int n0, c0;
    wn(3);
    rst_n = 1'b1;
    wn(2);
    // R1 reset state
    chk(sda_oe == 1'b0 && rx_valid == 1'b0 && tx_ready == 1'b0, "R1 outputs idle", sda_oe, 0);
    chk(addressed == 1'b0 && coll == 1'b0 && sda_out == 1'b0, "R1 flags idle", addressed, 0);

    // table walk: write transactions (R2 R3 R4 R7 R10)
    for (int k = 0; k < NV; k++) begin
      hold_long = VEC[k][16];
      n0 = rx_cnt;
      bus_start();
      send_byte({VEC[k][15:9], 1'b0}, ack);
      chk(ack == VEC[k][0], "R2/R3 address ack", ack, VEC[k][0]);
      chk(addressed == VEC[k][0], "R2 addressed flag", addressed, VEC[k][0]);
      wn(25);
      if (VEC[k][0]) chk(last_delay == (VEC[k][16] ? HL : HS) + 3, "R7 hold delay",
                         last_delay, (VEC[k][16] ? HL : HS) + 3);
      c0 = oe_cycles;
      send_byte(VEC[k][8:1], ack2);
      chk(ack2 == VEC[k][0], "R4 data ack", ack2, VEC[k][0]);
      if (VEC[k][0]) begin
        chk(rx_cnt == n0 + 1 && last_rx == VEC[k][8:1], "R4 rx byte", last_rx, VEC[k][8:1]);
      end else begin
        chk(rx_cnt == n0, "R3 no rx", rx_cnt - n0, 0);
        chk(oe_cycles == c0, "R3 no drive", oe_cycles - c0, 0);
      end
      bus_stop();
      wn(5);
      chk(addressed == 1'b0, "R10 stop idles", addressed, 0);
    end

    // R5 R6 read with valid byte then underrun, then NACK
    hold_long = 1'b0;
    tx_data = 8'hA5; tx_valid = 1'b1;
    n0 = rdy_cnt;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk(ack == 1'b1, "R2 read address ack", ack, 1);
    wn(8);
    tx_valid = 1'b0;
    chk(rdy_cnt == n0 + 1, "R5 tx_ready taken", rdy_cnt - n0, 1);
    recv_byte(d, 1'b1);
    chk(d == 8'hA5, "R5 read byte", d, 8'hA5);
    recv_byte(d, 1'b0);
    chk(d == 8'hFF, "R5 underrun sends ones", d, 8'hFF);
    chk(rdy_cnt == n0 + 1, "R5 no ready on underrun", rdy_cnt - n0, 1);
    wn(25);
    c0 = oe_cycles;
    tx_data = 8'h00; tx_valid = 1'b1;
    recv_byte(d, 1'b1);
    chk(oe_cycles == c0 && d == 8'hFF, "R6 silent after NACK", oe_cycles - c0, 0);
    tx_valid = 1'b0;
    bus_stop();

    // R8 collision: block sends a one, controller forces zero
    tx_data = 8'hFF; tx_valid = 1'b1;
    c0 = coll_cnt;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    wn(8);
    tx_valid = 1'b0;
    begin
      logic r;
      clk_bit(1'b0, r);
      for (int i = 0; i < 7; i++) clk_bit(1'b1, r);
      clk_bit(1'b1, r);
    end
    chk(coll_cnt == c0 + 1, "R8 collision pulse", coll_cnt - c0, 1);
    bus_stop();

    // R10 repeated start: write then read
    n0 = rx_cnt;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    send_byte(8'h42, ack);
    chk(rx_cnt == n0 + 1 && last_rx == 8'h42, "R4 rx before restart", last_rx, 8'h42);
    tx_data = 8'h3C; tx_valid = 1'b1;
    bus_restart();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk(ack == 1'b1, "R10 restart readdress", ack, 1);
    wn(8);
    tx_valid = 1'b0;
    recv_byte(d, 1'b0);
    chk(d == 8'h3C, "R10 read after restart", d, 8'h3C);
    bus_stop();

    // R9 disable while driving the acknowledge
    hold_long = 1'b0;
    bus_start();
    begin
      logic r;
      logic [7:0] a;
      a = {MY_ADDR, 1'b0};
      for (int i = 7; i >= 0; i--) clk_bit(a[i], r);
    end
    wn(25);
    chk(sda_oe == 1'b1, "R2 ack driven", sda_oe, 1);
    en = 1'b0;
    wn(1);
    chk(sda_oe == 1'b0, "R9 disable releases", sda_oe, 0);
    chk(addressed == 1'b0, "R9 disable idles", addressed, 0);
    en = 1'b1;
    begin
      logic r;
      clk_bit(1'b1, r);
    end
    bus_stop();
    chk(sda_out == 1'b0, "R1 sda_out zero", sda_out, 0);

    finish_run();
  end
endmodule